// File: doc/BRIEF.md
# Ownership-Bit Descriptor Ring Controller

This block holds a circular ring of descriptors in a small on-chip memory and runs both ends of it. A producer posts buffers one entry per cycle, and a consumer takes them in the order they were posted. Each entry carries a buffer pointer, a length, a status field, start/end-of-packet flags and an ownership bit. The ownership bit says which side may touch the entry's other fields.

A packet may span several entries. The producer writes every entry of the packet, but the first entry only passes to the consumer when the last entry has been written. The consumer therefore sees the whole packet appear at once. It returns entries one at a time and may write a status value back into each one. The producer then reclaims the returned buffers in ring order through its free pointer. A one-cycle strobe marks each handover in each direction.

The producer holds two pointers: fill and free. The consumer holds one: receive. With a power-of-two ring size, the pointers wrap by truncation. When every entry has been posted and not yet reclaimed, further posts are held off with a busy flag.

Top module: `ownRing`

## Requirements
- R1: After reset every entry belongs to the producer and all three pointers sit at entry 0. postBusy, rxAvail, freeAvail, txDone and rxDone are all 0.
- R2: A packet posted with postSop=1 and postEop=1 is handed to the consumer on the clock edge that accepts it. From the next cycle rxAvail=1, and rxAddr, rxLen and rxStatus show the posted values.
- R3: For a packet posted with postSop=1 on its first entry, postSop=postEop=0 on middle entries and postEop=1 only on its last entry, rxAvail stays 0 until the last entry is accepted. The whole packet then becomes available at once, and rxSop/rxEop repeat the posted flags entry by entry.
- R4: When rxTake=1 and rxAvail=1, the head entry goes back to the producer with rxRetStatus stored in its status field, and the receive pointer advances. rxDone is 1 in the following cycle only.
- R5: freeAvail=1 exactly when a returned entry has not yet been reclaimed. freeAddr and freeStatus show the oldest such entry. When freeReclaim=1 and freeAvail=1, the free pointer advances by one.
- R6: postBusy=1 when ENTRIES entries have been posted and not reclaimed. A post while postBusy=1 is ignored and changes no entry. Returning entries alone does not clear postBusy; a reclaim does.
- R7: rxTake while rxAvail=0, and freeReclaim while freeAvail=0, are ignored.
- R8: Pointers wrap modulo ENTRIES, and ring order is kept across the wrap.
- R9: The number of posted-but-unreclaimed entries never exceeds ENTRIES. The receive pointer always lies between the free and fill pointers.
- R10: txDone is 1 for one cycle after the accepting edge of each entry posted with postEop=1, and is 0 after every other post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postValid | input | 1 | Producer offers one entry |
| postAddr | input | ADDR_W | Buffer pointer of the offered entry |
| postLen | input | LEN_W | Byte count of the offered buffer |
| postStatus | input | STAT_W | Status written by the producer |
| postSop | input | 1 | Entry starts a packet |
| postEop | input | 1 | Entry ends a packet |
| postBusy | output | 1 | Ring full; post is held off |
| txDone | output | 1 | Producer handed a packet over |
| rxAvail | output | 1 | Head entry owned by the consumer |
| rxAddr | output | ADDR_W | Head entry buffer pointer |
| rxLen | output | LEN_W | Head entry length |
| rxStatus | output | STAT_W | Head entry status |
| rxSop | output | 1 | Head entry start flag |
| rxEop | output | 1 | Head entry end flag |
| rxTake | input | 1 | Consumer returns the head entry |
| rxRetStatus | input | STAT_W | Status written back on return |
| rxDone | output | 1 | Consumer returned an entry |
| freeAvail | output | 1 | A returned entry awaits reclaim |
| freeAddr | output | ADDR_W | Buffer pointer of that entry |
| freeStatus | output | STAT_W | Status returned with that entry |
| freeReclaim | input | 1 | Producer reclaims that entry |

## Verification
Directed sequences cover a one-entry packet, a three-entry packet, a completely full ring with an extra post offered, and a take on an empty ring. The three-entry packet separates per-packet handover from per-entry handover. The full ring separates counting unreclaimed entries from counting owned entries. A long constrained-random run then mixes packets of one to four entries with random take and reclaim rates across many pointer wraps. This exposes any loss of order, any wrong framing flag, and any status write-back that lands on the wrong entry.

// File: rtl/ownRingPkg.sv
package ownRingPkg;
  // Per-cycle commands issued by the control to the entry store
  typedef struct packed {
    logic wrEn;    // write entry at fill index
    logic ownNow;  // written entry passes to consumer immediately
    logic commit;  // pass held first entry of a packet to consumer
    logic ret;     // consumer returns head entry
  } ringStrobe_t;
endpackage

// File: rtl/ownRingCtrl.sv
module ownRingCtrl
  import ownRingPkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             postValid,
  input  logic             postSop,
  input  logic             postEop,
  input  logic             rxTake,
  input  logic             freeReclaim,
  input  logic             headOwned,
  output logic             postBusy,
  output logic             txDone,
  output logic             rxAvail,
  output logic             rxDone,
  output logic             freeAvail,
  output logic [IDX_W-1:0] fillIdx,
  output logic [IDX_W-1:0] firstIdx,
  output logic [IDX_W-1:0] recvIdx,
  output logic [IDX_W-1:0] freeIdx,
  output ringStrobe_t      strb
);
  // Pointers carry one extra lap bit so full and empty differ
  logic [PTR_W-1:0] fillPtr, freePtr, recvPtr;
  logic [PTR_W-1:0] usedCnt;
  logic [IDX_W-1:0] firstQ;
  logic postOk, takeOk, reclOk;

  assign usedCnt   = fillPtr - freePtr;
  assign postBusy  = (usedCnt == PTR_W'(ENTRIES));
  assign rxAvail   = headOwned;
  assign freeAvail = (freePtr != recvPtr);

  assign postOk = postValid && !postBusy;
  assign takeOk = rxTake && headOwned;
  assign reclOk = freeReclaim && freeAvail;

  assign fillIdx  = fillPtr[IDX_W-1:0];
  assign recvIdx  = recvPtr[IDX_W-1:0];
  assign freeIdx  = freePtr[IDX_W-1:0];
  assign firstIdx = firstQ;

  always_comb begin
    strb        = '0;
    strb.wrEn   = postOk;
    // a lone entry, or any entry past the first, is handed over at once
    strb.ownNow = !postSop || postEop;
    // the held first entry is handed over together with the last one
    strb.commit = postOk && postEop && !postSop;
    strb.ret    = takeOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillPtr <= '0;
      freePtr <= '0;
      recvPtr <= '0;
      firstQ  <= '0;
      txDone  <= 1'b0;
      rxDone  <= 1'b0;
    end else begin
      if (postOk) fillPtr <= fillPtr + 1'b1;
      if (postOk && postSop) firstQ <= fillIdx;
      if (takeOk) recvPtr <= recvPtr + 1'b1;
      if (reclOk) freePtr <= freePtr + 1'b1;
      txDone <= postOk && postEop;
      rxDone <= takeOk;
    end
  end

  // R9
  order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (usedCnt <= PTR_W'(ENTRIES)) && ((recvPtr - freePtr) <= usedCnt));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    postValid && postBusy |=> $stable(fillPtr));

  // R7
  idle_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTake && !rxAvail |=> $stable(recvPtr));

  // R7
  idle_recl_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeReclaim && !freeAvail |=> $stable(freePtr));
endmodule

// File: rtl/ownRingStore.sv
module ownRingStore
  import ownRingPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 10,
  parameter int STAT_W  = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strb,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [IDX_W-1:0]  firstIdx,
  input  logic [IDX_W-1:0]  recvIdx,
  input  logic [IDX_W-1:0]  freeIdx,
  input  logic [ADDR_W-1:0] postAddr,
  input  logic [LEN_W-1:0]  postLen,
  input  logic [STAT_W-1:0] postStatus,
  input  logic              postSop,
  input  logic              postEop,
  input  logic [STAT_W-1:0] rxRetStatus,
  output logic              headOwned,
  output logic [ADDR_W-1:0] rxAddr,
  output logic [LEN_W-1:0]  rxLen,
  output logic [STAT_W-1:0] rxStatus,
  output logic              rxSop,
  output logic              rxEop,
  output logic [ADDR_W-1:0] freeAddr,
  output logic [STAT_W-1:0] freeStatus
);
  logic [ADDR_W-1:0] addrMem [ENTRIES];
  logic [LEN_W-1:0]  lenMem  [ENTRIES];
  logic [STAT_W-1:0] statMem [ENTRIES];
  logic [ENTRIES-1:0] sopMem, eopMem;
  logic [ENTRIES-1:0] owner;  // 1 = consumer owns the entry

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      addrMem[fillIdx] <= postAddr;
      lenMem[fillIdx]  <= postLen;
      sopMem[fillIdx]  <= postSop;
      eopMem[fillIdx]  <= postEop;
    end
    // producer and consumer never write the same index in one cycle
    if (strb.wrEn) statMem[fillIdx] <= postStatus;
    if (strb.ret)  statMem[recvIdx] <= rxRetStatus;
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_own
      always_ff @(posedge clk) begin
        if (!rstN) begin
          owner[e] <= 1'b0;
        end else if (strb.wrEn && fillIdx == IDX_W'(e)) begin
          owner[e] <= strb.ownNow;
        end else if (strb.commit && firstIdx == IDX_W'(e)) begin
          owner[e] <= 1'b1;
        end else if (strb.ret && recvIdx == IDX_W'(e)) begin
          owner[e] <= 1'b0;
        end
      end
    end
  endgenerate

  assign headOwned  = owner[recvIdx];
  assign rxAddr     = addrMem[recvIdx];
  assign rxLen      = lenMem[recvIdx];
  assign rxStatus   = statMem[recvIdx];
  assign rxSop      = sopMem[recvIdx];
  assign rxEop      = eopMem[recvIdx];
  assign freeAddr   = addrMem[freeIdx];
  assign freeStatus = statMem[freeIdx];

  // R3
  first_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !owner[firstIdx]);

  // R4
  ret_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ret |-> owner[recvIdx]);

  // R3
  write_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !owner[fillIdx]);
endmodule

// File: rtl/ownRing.sv
module ownRing
  import ownRingPkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 512,
  parameter int STAT_W    = 4,
  localparam int LEN_W = $clog2(BUF_BYTES) + 1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic [ADDR_W-1:0] postAddr,
  input  logic [LEN_W-1:0]  postLen,
  input  logic [STAT_W-1:0] postStatus,
  input  logic              postSop,
  input  logic              postEop,
  output logic              postBusy,
  output logic              txDone,
  output logic              rxAvail,
  output logic [ADDR_W-1:0] rxAddr,
  output logic [LEN_W-1:0]  rxLen,
  output logic [STAT_W-1:0] rxStatus,
  output logic              rxSop,
  output logic              rxEop,
  input  logic              rxTake,
  input  logic [STAT_W-1:0] rxRetStatus,
  output logic              rxDone,
  output logic              freeAvail,
  output logic [ADDR_W-1:0] freeAddr,
  output logic [STAT_W-1:0] freeStatus,
  input  logic              freeReclaim
);
  ringStrobe_t      strb;
  logic [IDX_W-1:0] fillIdx, firstIdx, recvIdx, freeIdx;
  logic             headOwned;

  ownRingCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postSop(postSop), .postEop(postEop),
    .rxTake(rxTake), .freeReclaim(freeReclaim), .headOwned(headOwned),
    .postBusy(postBusy), .txDone(txDone), .rxAvail(rxAvail),
    .rxDone(rxDone), .freeAvail(freeAvail),
    .fillIdx(fillIdx), .firstIdx(firstIdx), .recvIdx(recvIdx),
    .freeIdx(freeIdx), .strb(strb)
  );

  ownRingStore #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fillIdx(fillIdx), .firstIdx(firstIdx), .recvIdx(recvIdx),
    .freeIdx(freeIdx),
    .postAddr(postAddr), .postLen(postLen), .postStatus(postStatus),
    .postSop(postSop), .postEop(postEop), .rxRetStatus(rxRetStatus),
    .headOwned(headOwned),
    .rxAddr(rxAddr), .rxLen(rxLen), .rxStatus(rxStatus),
    .rxSop(rxSop), .rxEop(rxEop),
    .freeAddr(freeAddr), .freeStatus(freeStatus)
  );
endmodule

// File: tb/ownRing_tb.sv
module ownRing_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        postValid = 0, postSop = 0, postEop = 0;
  logic [31:0] postAddr = '0;
  logic [9:0]  postLen = '0;
  logic [3:0]  postStatus = '0, rxRetStatus = '0;
  logic        rxTake = 0, freeReclaim = 0;
  logic        postBusy, txDone, rxAvail, rxSop, rxEop, rxDone, freeAvail;
  logic [31:0] rxAddr, freeAddr;
  logic [9:0]  rxLen;
  logic [3:0]  rxStatus, freeStatus;

  always #4 clk = ~clk;

  ownRing #(.ENTRIES(N), .ADDR_W(32), .BUF_BYTES(512), .STAT_W(4)) u_dut (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postAddr(postAddr), .postLen(postLen),
    .postStatus(postStatus), .postSop(postSop), .postEop(postEop),
    .postBusy(postBusy), .txDone(txDone),
    .rxAvail(rxAvail), .rxAddr(rxAddr), .rxLen(rxLen), .rxStatus(rxStatus),
    .rxSop(rxSop), .rxEop(rxEop), .rxTake(rxTake), .rxRetStatus(rxRetStatus),
    .rxDone(rxDone), .freeAvail(freeAvail), .freeAddr(freeAddr),
    .freeStatus(freeStatus), .freeReclaim(freeReclaim)
  );

  int vecCnt = 0, badCnt = 0;
  bit finished = 0;

  // reference model: monotonic counts, index = count % N
  int mFill = 0, mFree = 0, mRecv = 0, mVis = 0;
  bit expTx = 0, expRx = 0;
  logic [31:0] mAddr [N];
  logic [9:0]  mLen  [N];
  logic [3:0]  mSt   [N];
  bit          mSop  [N];
  bit          mEop  [N];

  function automatic bit mBusy();
    return (mFill - mFree) == N;
  endfunction
  function automatic bit mAvail();
    return mRecv < mVis;
  endfunction
  function automatic bit mFreeAvail();
    return mFree < mRecv;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    cmp("R6", "postBusy", 32'(postBusy), 32'(mBusy()));
    cmp("R3", "rxAvail", 32'(rxAvail), 32'(mAvail()));
    cmp("R5", "freeAvail", 32'(freeAvail), 32'(mFreeAvail()));
    cmp("R10", "txDone", 32'(txDone), 32'(expTx));
    cmp("R4", "rxDone", 32'(rxDone), 32'(expRx));
    if (mAvail()) begin
      cmp("R2", "rxAddr", rxAddr, mAddr[mRecv % N]);
      cmp("R2", "rxLen", 32'(rxLen), 32'(mLen[mRecv % N]));
      cmp("R2", "rxStatus", 32'(rxStatus), 32'(mSt[mRecv % N]));
      cmp("R3", "rxSop", 32'(rxSop), 32'(mSop[mRecv % N]));
      cmp("R3", "rxEop", 32'(rxEop), 32'(mEop[mRecv % N]));
    end
    if (mFreeAvail()) begin
      cmp("R5", "freeAddr", freeAddr, mAddr[mFree % N]);
      cmp("R4", "freeStatus", 32'(freeStatus), 32'(mSt[mFree % N]));
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic step(bit pv, logic [31:0] a, logic [9:0] l, logic [3:0] s,
                      bit sop, bit eop, bit tk, logic [3:0] rs, bit rc);
    bit busy0, avail0, favail0;
    checkAll();
    postValid = pv; postAddr = a; postLen = l; postStatus = s;
    postSop = sop; postEop = eop; rxTake = tk; rxRetStatus = rs;
    freeReclaim = rc;
    busy0 = mBusy(); avail0 = mAvail(); favail0 = mFreeAvail();
    expTx = 0; expRx = 0;
    if (pv && !busy0) begin
      mAddr[mFill % N] = a; mLen[mFill % N] = l; mSt[mFill % N] = s;
      mSop[mFill % N] = sop; mEop[mFill % N] = eop;
      mFill++;
      if (eop) begin mVis = mFill; expTx = 1; end
    end
    if (tk && avail0) begin
      mSt[mRecv % N] = rs; mRecv++; expRx = 1;
    end
    if (rc && favail0) mFree++;
    @(negedge clk);
    postValid = 0; rxTake = 0; freeReclaim = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic post1(logic [31:0] a, bit sop, bit eop);
    step(1, a, 10'(a[8:0]) + 10'd1, 4'(a[3:0]), sop, eop, 0, 0, 0);
  endtask
  task automatic take(logic [3:0] rs);
    step(0, 0, 0, 0, 0, 0, 1, rs, 0);
  endtask
  task automatic reclaim();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      badCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int pktLen = 0, pos = 0;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    cmp("R1", "postBusy", 32'(postBusy), 0);
    cmp("R1", "rxAvail", 32'(rxAvail), 0);
    cmp("R1", "freeAvail", 32'(freeAvail), 0);
    cmp("R1", "txDone", 32'(txDone), 0);
    cmp("R1", "rxDone", 32'(rxDone), 0);

    // R2: single-entry packet visible right after the accepting edge
    post1(32'h1000_0040, 1, 1);
    cmp("R2", "rxAvail after single post", 32'(rxAvail), 1);
    cmp("R10", "txDone after single post", 32'(txDone), 1);
    take(4'h5);
    cmp("R4", "rxDone after take", 32'(rxDone), 1);
    idle();
    cmp("R4", "rxDone one cycle only", 32'(rxDone), 0);
    reclaim();

    // R3: three-entry packet held until its last entry
    post1(32'h2000_0001, 1, 0);
    post1(32'h2000_0002, 0, 0);
    cmp("R3", "rxAvail before last entry", 32'(rxAvail), 0);
    cmp("R10", "txDone on middle entry", 32'(txDone), 0);
    post1(32'h2000_0003, 0, 1);
    cmp("R3", "rxAvail after last entry", 32'(rxAvail), 1);
    take(4'h1); take(4'h2); take(4'h3);
    reclaim(); reclaim(); reclaim();

    // R6: full ring holds off posts; returning alone does not free
    for (int i = 0; i < N; i++) post1(32'h3000_0000 + 32'(i), 1, 1);
    cmp("R6", "postBusy when full", 32'(postBusy), 1);
    post1(32'hDEAD_BEEF, 1, 1);
    for (int i = 0; i < N; i++) take(4'(i));
    cmp("R6", "postBusy after returns only", 32'(postBusy), 1);
    cmp("R6", "rxAvail: rejected post left no entry", 32'(rxAvail), 0);
    reclaim();
    cmp("R6", "postBusy after one reclaim", 32'(postBusy), 0);
    for (int i = 1; i < N; i++) reclaim();

    // R7: take and reclaim on an empty ring
    take(4'hF);
    cmp("R7", "rxDone after empty take", 32'(rxDone), 0);
    reclaim();
    cmp("R7", "freeAvail after empty reclaim", 32'(freeAvail), 0);

    // R8: random traffic over many wraps
    for (int c = 0; c < 6000; c++) begin
      bit pv, tk, rc, sop, eop;
      logic [31:0] a;
      if (pos == pktLen) begin pktLen = 1 + int'($urandom % 4); pos = 0; end
      pv = ($urandom % 10) < 6;
      tk = ($urandom % 10) < 5;
      rc = ($urandom % 10) < 5;
      sop = (pos == 0);
      eop = (pos == pktLen - 1);
      a = $urandom;
      if (pv && !mBusy()) pos++;
      step(pv, a, 10'($urandom % 512) + 10'd1, 4'($urandom), sop, eop,
           tk, 4'($urandom), rc);
    end
    checkAll();

    finished = 1;
    summary();
    $finish;
  end
endmodule